// File: doc/BRIEF.md
# DDR2 Command Decoder and Bank State Tracker

This block sits on the command side of a DDR2 memory model or controller. On every rising clock edge it samples chip select, the three active-low strobes (row strobe, column strobe, write enable), the bank address and the address bus. It turns them into one decoded command and keeps, for each bank, whether a row is open and which row that is.

Each sampled command is reported one cycle later on registered outputs. These carry the command code, the target bank, the address field reinterpreted for that command, the auto-precharge and all-banks qualifiers, the row held open in the addressed bank and an illegal-command flag. A command that breaks the bank protocol is flagged and leaves every bank untouched.

A read or write carrying auto-precharge keeps its bank open for a programmable number of cycles, standing for the burst. When that count runs out, the bank closes by itself.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: While cs_n is sampled high, the command is treated as a no-op: cmd_o reads 0 on the next cycle and no bank changes state, whatever the strobes carry.
- R2: With cs_n low, {ras_n,cas_n,we_n} decodes as follows, and cmd_o reports the code shown: 011 activate (1), 101 read (2), 100 write (3), 010 precharge (4), 001 refresh (5), 000 mode load (6), 111 no-op (0), 110 reserved (7).
- R3: An activate to a closed bank opens it and stores the row from addr. field_o shows that row, and later reads or writes to the bank return it on open_row_o.
- R4: On a read or write, field_o is addr with bit 10 cleared, auto_pre_o is addr bit 10, bank_o is ba and open_row_o is the row held by that bank.
- R5: A precharge with addr bit 10 low closes only the bank selected by ba, and all_banks_o reads 0.
- R6: A precharge with addr bit 10 high closes every bank, and all_banks_o reads 1.
- R7: On a mode load, bank_o carries ba as the register select and field_o carries addr as the opcode. No bank changes state.
- R8: An activate to an open bank, or a read or write to a closed bank, raises illegal_o for one cycle and leaves all bank state unchanged.
- R9: A refresh while any bank is open raises illegal_o. A refresh with all banks closed is legal.
- R10: A legal read or write with addr bit 10 high closes its bank exactly BURST_CYC cycles after the command is sampled. A new auto-precharge access to the same bank restarts that count.
- R11: The reserved code raises illegal_o and changes no bank.
- R12: While rst is high, all banks are closed and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address / register select |
| addr | input | 14 | Row, column with auto-precharge bit, or opcode |
| cmd_o | output | 3 | Decoded command code |
| bank_o | output | 3 | Target bank or register select |
| field_o | output | 14 | Row, column or opcode of the command |
| auto_pre_o | output | 1 | Auto-precharge requested on read/write |
| all_banks_o | output | 1 | Precharge applies to all banks |
| open_row_o | output | 14 | Row held open in the addressed bank (read/write) |
| illegal_o | output | 1 | Command broke the bank protocol |
| bank_open_o | output | 8 | Open flag per bank |

## Verification
Because bank state is registered, a wrong open flag or stored row cannot stay hidden. It shows one cycle after the command that caused it, on bank_open_o. It shows again on the next access to that bank, through open_row_o or a wrong illegal_o.

An auto-precharge timer that is off by one closes its bank a cycle early or late, so bank_open_o is checked after every idle cycle that follows such an access. Every bank is activated, read, written and precharged, and protocol-breaking commands are sent against both open and closed banks. This makes sure that a wrong target index or a flag that leaks into state appears within a few cycles.

// File: rtl/ddr2_trk_pkg.sv
package ddr2_trk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6,
    CMD_RSV = 3'd7
  } cmd_e;
endpackage

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
  import ddr2_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        3'b111:  cmd = CMD_NOP;
        default: cmd = CMD_RSV;
      endcase
    end
  end
endmodule

// File: rtl/ddr2_bank_slot.sv
module ddr2_bank_slot #(
  parameter int ADDR_W    = 14,
  parameter int BURST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_i,
  input  logic              close_i,
  input  logic              ap_i,
  input  logic [ADDR_W-1:0] row_i,
  output logic              open_o,
  output logic [ADDR_W-1:0] row_o
);
  localparam int CNT_W = $clog2(BURST_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURST_CYC);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic              open_q;
  logic [ADDR_W-1:0] row_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      row_q  <= '0;
      cnt_q  <= '0;
    end else if (close_i) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (act_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (ap_i) begin
      cnt_q  <= CNT_LOAD;
    end else if (cnt_q == CNT_ONE) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - CNT_ONE;
    end
  end

  assign open_o = open_q;
  assign row_o  = row_q;

  // R10: expiring timer closes the bank on the following edge
  p_ap_close_r10: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_ONE && !close_i && !act_i && !ap_i) |=> !open_q);

  // R3: activate opens the bank and captures the row
  p_act_opens_r3: assert property (@(posedge clk) disable iff (rst)
    (act_i && !close_i) |=> (open_q && row_q == $past(row_i)));
endmodule

// File: rtl/ddr2_cmd_tracker.sv
module ddr2_cmd_tracker
  import ddr2_trk_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 14,
  parameter int AP_BIT    = 10,
  parameter int BURST_CYC = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cs_n,
  input  logic                         ras_n,
  input  logic                         cas_n,
  input  logic                         we_n,
  input  logic [$clog2(NUM_BANKS)-1:0] ba,
  input  logic [ADDR_W-1:0]            addr,
  output logic [2:0]                   cmd_o,
  output logic [$clog2(NUM_BANKS)-1:0] bank_o,
  output logic [ADDR_W-1:0]            field_o,
  output logic                         auto_pre_o,
  output logic                         all_banks_o,
  output logic [ADDR_W-1:0]            open_row_o,
  output logic                         illegal_o,
  output logic [NUM_BANKS-1:0]         bank_open_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam logic [ADDR_W-1:0] COL_MASK = ~(ADDR_W'(1) << AP_BIT);

  cmd_e              dec;
  logic              tgt_open;
  logic              illegal_c;
  logic              is_rw;
  logic [NUM_BANKS-1:0] open_vec;
  logic [NUM_BANKS-1:0] act_vec, close_vec, ap_vec;
  logic [ADDR_W-1:0] row_arr [NUM_BANKS];

  ddr2_cmd_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (dec)
  );

  assign tgt_open = open_vec[ba];
  assign is_rw    = (dec == CMD_RD) || (dec == CMD_WR);

  always_comb begin
    case (dec)
      CMD_ACT:        illegal_c = tgt_open;
      CMD_RD, CMD_WR: illegal_c = !tgt_open;
      CMD_REF:        illegal_c = |open_vec;
      CMD_RSV:        illegal_c = 1'b1;
      default:        illegal_c = 1'b0;
    endcase
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic sel;
    assign sel          = (ba == BANK_W'(i));
    assign act_vec[i]   = (dec == CMD_ACT) && sel && !illegal_c;
    assign close_vec[i] = (dec == CMD_PRE) && (addr[AP_BIT] || sel);
    assign ap_vec[i]    = is_rw && sel && !illegal_c && addr[AP_BIT];

    ddr2_bank_slot #(
      .ADDR_W   (ADDR_W),
      .BURST_CYC(BURST_CYC)
    ) u_slot (
      .clk    (clk),
      .rst    (rst),
      .act_i  (act_vec[i]),
      .close_i(close_vec[i]),
      .ap_i   (ap_vec[i]),
      .row_i  (addr),
      .open_o (open_vec[i]),
      .row_o  (row_arr[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o       <= 3'(CMD_NOP);
      bank_o      <= '0;
      field_o     <= '0;
      auto_pre_o  <= 1'b0;
      all_banks_o <= 1'b0;
      open_row_o  <= '0;
      illegal_o   <= 1'b0;
    end else begin
      cmd_o       <= 3'(dec);
      illegal_o   <= illegal_c;
      bank_o      <= '0;
      field_o     <= '0;
      auto_pre_o  <= 1'b0;
      all_banks_o <= 1'b0;
      open_row_o  <= '0;
      case (dec)
        CMD_ACT: begin
          bank_o  <= ba;
          field_o <= addr;
        end
        CMD_RD, CMD_WR: begin
          bank_o     <= ba;
          field_o    <= addr & COL_MASK;
          auto_pre_o <= addr[AP_BIT];
          open_row_o <= illegal_c ? '0 : row_arr[ba];
        end
        CMD_PRE: begin
          bank_o      <= ba;
          all_banks_o <= addr[AP_BIT];
        end
        CMD_MRS: begin
          bank_o  <= ba;
          field_o <= addr;
        end
        default: ;
      endcase
    end
  end

  assign bank_open_o = open_vec;

  // R1: deselected cycle reports a no-op
  p_deselect_nop_r1: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (cmd_o == 3'(CMD_NOP)));

  // R6: precharge-all leaves no bank open
  p_pre_all_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'(CMD_PRE) && all_banks_o) |-> (bank_open_o == '0));

  // R9: an accepted refresh found every bank closed
  p_ref_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'(CMD_REF) && !illegal_o) |-> ($past(bank_open_o) == '0));

  // R11: reserved code is always flagged
  p_rsv_flag_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'(CMD_RSV)) |-> illegal_o);
endmodule

// File: tb/ddr2_cmd_tracker_tb.sv
module ddr2_cmd_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int AW = 14;
  localparam int APB = 10;
  localparam int BURST = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0] ba = '0;
  logic [AW-1:0] addr = '0;
  logic [2:0] cmd_o, bank_o;
  logic [AW-1:0] field_o, open_row_o;
  logic auto_pre_o, all_banks_o, illegal_o;
  logic [NB-1:0] bank_open_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  logic          m_open [NB];
  logic [AW-1:0] m_row  [NB];
  int            m_cnt  [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr2_cmd_tracker #(.NUM_BANKS(NB), .ADDR_W(AW), .AP_BIT(APB), .BURST_CYC(BURST)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .cmd_o(cmd_o), .bank_o(bank_o), .field_o(field_o),
    .auto_pre_o(auto_pre_o), .all_banks_o(all_banks_o), .open_row_o(open_row_o),
    .illegal_o(illegal_o), .bank_open_o(bank_open_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int decode(logic c, logic [2:0] code);
    if (c) return 0;
    case (code)
      3'b011: return 1;
      3'b101: return 2;
      3'b100: return 3;
      3'b010: return 4;
      3'b001: return 5;
      3'b000: return 6;
      3'b111: return 0;
      default: return 7;
    endcase
  endfunction

  // drive one command, advance one edge, compare against the model
  task automatic issue(logic c, logic [2:0] code, logic [2:0] b, logic [AW-1:0] a, string req);
    int ec, eb, ef, eap, eall, erow, eill, eopen;
    bit any_open, tgt;
    @(negedge clk);
    cs_n = c; {ras_n, cas_n, we_n} = code; ba = b; addr = a;
    ec = decode(c, code);
    any_open = 0;
    for (int j = 0; j < NB; j++) if (m_open[j]) any_open = 1;
    tgt = m_open[b];
    eill = (ec == 1 && tgt) || ((ec == 2 || ec == 3) && !tgt) || (ec == 5 && any_open) || ec == 7;
    eb = (ec == 1 || ec == 2 || ec == 3 || ec == 4 || ec == 6) ? int'(b) : 0;
    ef = (ec == 1 || ec == 6) ? int'(a) : ((ec == 2 || ec == 3) ? int'(a & ~(14'd1 << APB)) : 0);
    eap = (ec == 2 || ec == 3) ? int'(a[APB]) : 0;
    eall = (ec == 4) ? int'(a[APB]) : 0;
    erow = ((ec == 2 || ec == 3) && !eill) ? int'(m_row[b]) : 0;
    for (int j = 0; j < NB; j++) begin
      bit sel;
      sel = (j == int'(b));
      if (ec == 4 && (a[APB] || sel)) begin
        m_open[j] = 0; m_cnt[j] = 0;
      end else if (ec == 1 && sel && !eill) begin
        m_open[j] = 1; m_row[j] = a;
      end else if ((ec == 2 || ec == 3) && sel && !eill && a[APB]) begin
        m_cnt[j] = BURST;
      end else if (m_cnt[j] == 1) begin
        m_open[j] = 0; m_cnt[j] = 0;
      end else if (m_cnt[j] > 0) begin
        m_cnt[j]--;
      end
    end
    eopen = 0;
    for (int j = 0; j < NB; j++) eopen |= int'(m_open[j]) << j;
    @(posedge clk); #1;
    chk(req, "cmd_o", int'(cmd_o), ec);
    chk(req, "illegal_o", int'(illegal_o), eill);
    chk(req, "bank_open_o", int'(bank_open_o), eopen);
    chk(req, "bank_o", int'(bank_o), eb);
    chk(req, "field_o", int'(field_o), ef);
    chk(req, "auto_pre_o", int'(auto_pre_o), eap);
    chk(req, "all_banks_o", int'(all_banks_o), eall);
    chk(req, "open_row_o", int'(open_row_o), erow);
  endtask

  task automatic nop(string req);
    issue(1'b0, 3'b111, 3'd0, '0, req);
  endtask

  initial begin
    for (int j = 0; j < NB; j++) begin m_open[j] = 0; m_row[j] = '0; m_cnt[j] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    chk("R12", "cmd_o", int'(cmd_o), 0);
    chk("R12", "bank_open_o", int'(bank_open_o), 0);
    chk("R12", "field_o", int'(field_o), 0);
    chk("R12", "illegal_o", int'(illegal_o), 0);
    @(negedge clk); rst = 1'b0;
    nop("R2");
    // R1: deselect sweep with every strobe code
    for (int k = 0; k < 8; k++) issue(1'b1, 3'(k), 3'(k), 14'h3fff, "R1");
    // R3: open each bank with a distinct row
    for (int b = 0; b < NB; b++) issue(1'b0, 3'b011, 3'(b), 14'((b * 613 + 7) & 14'h3bff), "R3");
    // R1 again with banks open
    for (int k = 0; k < 8; k++) issue(1'b1, 3'(k), 3'(7 - k), 14'h0400, "R1");
    // R8: activate to open bank
    issue(1'b0, 3'b011, 3'd3, 14'h1234, "R8");
    // R9: refresh with banks open
    issue(1'b0, 3'b001, 3'd0, '0, "R9");
    // R4: reads and writes without auto-precharge
    for (int b = 0; b < NB; b++) issue(1'b0, 3'b101, 3'(b), 14'((b * 97 + 3) & 14'h3bff), "R4");
    for (int b = 0; b < NB; b++) issue(1'b0, 3'b100, 3'(b), 14'(14'h3bff - b), "R4");
    // R11: reserved code
    issue(1'b0, 3'b110, 3'd2, 14'h0555, "R11");
    // R7: mode loads with every select
    for (int b = 0; b < NB; b++) issue(1'b0, 3'b000, 3'(b), 14'(b * 1111 + 5), "R7");
    // R5: single-bank precharge; other bits set except bit 10
    issue(1'b0, 3'b010, 3'd2, 14'h3bff, "R5");
    issue(1'b0, 3'b101, 3'd2, 14'h0010, "R8");
    issue(1'b0, 3'b100, 3'd2, 14'h0011, "R8");
    // R10: write with auto-precharge, then idle cycles
    issue(1'b0, 3'b100, 3'd5, 14'h0420, "R10");
    for (int k = 0; k < BURST + 1; k++) nop("R10");
    // R10: restart of count by a second auto-precharge access
    issue(1'b0, 3'b101, 3'd6, 14'h0401, "R10");
    nop("R10"); nop("R10");
    issue(1'b0, 3'b101, 3'd6, 14'h0402, "R10");
    for (int k = 0; k < BURST + 1; k++) nop("R10");
    // R6: precharge all
    issue(1'b0, 3'b010, 3'd1, 14'h0400, "R6");
    // R9: refresh with all banks closed
    issue(1'b0, 3'b001, 3'd0, '0, "R9");
    // R8: reads/writes to closed banks
    for (int b = 0; b < NB; b++) issue(1'b0, 3'(b[0] ? 3'b101 : 3'b100), 3'(b), 14'h0003, "R8");
    // R3: reopen and read back row
    issue(1'b0, 3'b011, 3'd0, 14'h2abc, "R3");
    issue(1'b0, 3'b101, 3'd0, 14'h0007, "R3");
    issue(1'b0, 3'b011, 3'd7, 14'h1555, "R3");
    issue(1'b0, 3'b100, 3'd7, 14'h0008, "R3");
    nop("R2");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule